// File: doc/BRIEF.md
# Multi-Phase Voltage Sag Detector

The block watches three phase-voltage sample streams and reports sags. Each stream delivers a signed 24-bit sample that has already been high-pass filtered, together with a zero-crossing strobe for that phase. The block takes the magnitude of each sample and compares it with a programmable level. A phase is declared in sag once it has stayed below that level across a programmable number of half-line cycles. The half-line cycles are counted on the phase's zero-crossing strobes.

Software programs the block through a small register port, one write per cycle. It sets the level, sets the cycle count and enables the interrupt. It reads back the status and the per-phase flags. It acknowledges a sag by writing one to the status bit. That single write clears the summary bit and every phase flag together, and releases the active-low interrupt line. Each phase has its own half-cycle counter. Writing the cycle-count register restarts all of these counters, so the first result after the write covers a whole qualifying period. Writing the level register leaves the counters running.

Register map, 3-bit word address, 32-bit data:
- 0: level, in bits 23:0.
- 1: cycle count, in bits 7:0.
- 2: interrupt enable, in bit 16.
- 3: sag status, in bit 16. Writing 1 to this bit clears it.
- 4: phase flags, bit 12 + p for phase p (0, 1, 2). Read only.
- Every other address reads as zero.

Top module: `vsag_monitor`

## Requirements
- R1: On a cycle with `smp_vld` high, a phase counts as below only when the two's-complement magnitude of its sample is strictly less than the effective level. A magnitude equal to or above the level counts as not below.
- R2: A sag is raised on a phase by the zero-crossing strobe that completes N consecutive strobes with no at-or-above sample between them, where N is the cycle-count register. From the cycle after that strobe, status bit 16 (address 3) reads 1 and phase flag bit 12+p (address 4) reads 1. Samples taken without a strobe do not advance the count.
- R3: Once a phase has raised a sag, it raises no further sag until an at-or-above sample re-arms it. After re-arming, a full count of N strobes is needed again.
- R4: Writing the level register does not restart the half-cycle counts.
- R5: Writing the cycle-count register restarts the counts of all phases, so N fresh strobes are needed. A cycle count of 0 never raises a sag.
- R6: When sags are raised in a cycle, the phase flags become exactly the set of phases raising in that cycle. Flags of phases raised earlier are cleared, and the status bit stays 1.
- R7: `irq_n` is low exactly while status bit 16 and the enable bit 16 (address 2) are both 1. Its timing is the same cycle the status bit reads 1, or the cycle after the enable is written.
- R8: Writing address 3 with bit 16 = 1 clears the status bit and all phase flags, and `irq_n` reads high from the next cycle. A write with bit 16 = 0 changes nothing. A sag raised in the same cycle takes precedence over the clear.
- R9: A level of 0 or 1 gives an effective threshold of zero, so no sag is ever raised.
- R10: The level reads back at address 0 with bits 31:24 zero; the cycle count reads back at address 1 in bits 7:0.
- R11: After reset all registers read zero and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample and strobe inputs are valid this cycle |
| smp_data | input | 72 | Three signed samples, phase p in bits 24p+23:24p |
| smp_zx | input | 3 | Zero-crossing strobe per phase |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from registered state |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A sample or strobe presented in cycle t passes through a combinational magnitude compare and the counter compare, and lands in the status registers at the edge that ends cycle t. Status, flags and `irq_n` are therefore valid from cycle t+1. A register write in cycle t is likewise visible on the read port from cycle t+1. The driver holds each stimulus for exactly one cycle and releases it on the falling edge. It then queues the expected read values. The monitor pops each one at a later falling edge, applies the read address, and compares a nanosecond later, once every result is settled and well clear of the rising edge.

// File: rtl/vsag_pkg.sv
package vsag_pkg;
    // Bit positions that software decodes
    localparam int STAT_BIT = 16;
    localparam int FLAG_LSB = 12;

    // Word addresses of the register port
    localparam int ADDR_LVL = 0;
    localparam int ADDR_CYC = 1;
    localparam int ADDR_MSK = 2;
    localparam int ADDR_STS = 3;
    localparam int ADDR_FLG = 4;
endpackage

// File: rtl/vsag_level_cmp.sv
module vsag_level_cmp #(
    parameter int SW = 24
) (
    input  logic [SW-1:0] sample_i,
    input  logic [SW-1:0] thr_i,
    output logic          below_o
);
    logic [SW-1:0] mag;

    always_comb begin
        // Two's-complement magnitude; the most negative code maps to 2^(SW-1)
        mag     = sample_i[SW-1] ? (~sample_i + SW'(1)) : sample_i;
        below_o = (mag < thr_i);
    end
endmodule

// File: rtl/vsag_phase_qual.sv
module vsag_phase_qual #(
    parameter int CYC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             below_i,
    input  logic             zx_i,
    input  logic             restart_i,
    input  logic [CYC_W-1:0] cyc_i,
    output logic             evt_o
);
    typedef struct packed {
        logic [CYC_W-1:0] cnt;
    } qual_t;

    qual_t q, d;
    logic [CYC_W-1:0] cnt_inc;

    always_comb begin
        d       = q;
        evt_o   = 1'b0;
        cnt_inc = q.cnt + CYC_W'(1);
        if (restart_i) begin
            d.cnt = '0;
        end else if (vld_i) begin
            if (!below_i) begin
                // re-arm: any at-or-above sample restarts qualification
                d.cnt = '0;
            end else if (zx_i && (q.cnt != cyc_i)) begin
                // saturates at the target so a held sag fires only once
                d.cnt = cnt_inc;
                evt_o = (cnt_inc == cyc_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/vsag_csr.sv
module vsag_csr
    import vsag_pkg::*;
#(
    parameter int NPH   = 3,
    parameter int SW    = 24,
    parameter int CYC_W = 8,
    parameter int AW    = 3,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic [NPH-1:0]   evt_i,
    output logic [SW-1:0]    thr_o,
    output logic [CYC_W-1:0] cyc_o,
    output logic             restart_o,
    output logic             status_o,
    output logic             mask_o,
    output logic [NPH-1:0]   flags_o,
    output logic [SW-1:0]    lvl_o,
    output logic             irq_n
);
    typedef struct packed {
        logic [SW-1:0]    lvl;
        logic [CYC_W-1:0] cyc;
        logic             mask;
        logic             status;
        logic [NPH-1:0]   flags;
        logic             irq_n;
    } csr_t;

    csr_t q, d;
    logic wr_unused;

    assign wr_unused = ^wr_data;

    always_comb begin
        d         = q;
        restart_o = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                AW'(ADDR_LVL): d.lvl = wr_data[SW-1:0];
                AW'(ADDR_CYC): begin
                    d.cyc     = wr_data[CYC_W-1:0];
                    restart_o = 1'b1;
                end
                AW'(ADDR_MSK): d.mask = wr_data[STAT_BIT];
                AW'(ADDR_STS): begin
                    if (wr_data[STAT_BIT]) begin
                        d.status = 1'b0;
                        d.flags  = '0;
                    end
                end
                default: ;
            endcase
        end
        // a new sag wins over a same-cycle acknowledge
        if (|evt_i) begin
            d.status = 1'b1;
            d.flags  = evt_i;
        end
        d.irq_n = !(d.status && d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{lvl: '0, cyc: '0, mask: 1'b0, status: 1'b0, flags: '0, irq_n: 1'b1};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(ADDR_LVL): rd_data[SW-1:0]           = q.lvl;
            AW'(ADDR_CYC): rd_data[CYC_W-1:0]        = q.cyc;
            AW'(ADDR_MSK): rd_data[STAT_BIT]         = q.mask;
            AW'(ADDR_STS): rd_data[STAT_BIT]         = q.status;
            AW'(ADDR_FLG): rd_data[FLAG_LSB +: NPH]  = q.flags;
            default: ;
        endcase
    end

    // levels 0 and 1 both collapse to a zero threshold
    assign thr_o    = (q.lvl <= SW'(1)) ? '0 : q.lvl;
    assign cyc_o    = q.cyc;
    assign status_o = q.status;
    assign mask_o   = q.mask;
    assign flags_o  = q.flags;
    assign lvl_o    = q.lvl;
    assign irq_n    = q.irq_n;
endmodule

// File: rtl/vsag_monitor.sv
module vsag_monitor #(
    parameter int NPH   = 3,
    parameter int SW    = 24,
    parameter int CYC_W = 8,
    parameter int AW    = 3,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [NPH*SW-1:0] smp_data,
    input  logic [NPH-1:0]    smp_zx,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq_n
);
    logic [SW-1:0]    thr;
    logic [CYC_W-1:0] cyc;
    logic             cyc_restart;
    logic [NPH-1:0]   below;
    logic [NPH-1:0]   evt_w;
    logic             status_w;
    logic             mask_w;
    logic [NPH-1:0]   flags_w;
    logic [SW-1:0]    lvl_w;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        vsag_level_cmp #(.SW(SW)) u_cmp (
            .sample_i (smp_data[p*SW +: SW]),
            .thr_i    (thr),
            .below_o  (below[p])
        );
        vsag_phase_qual #(.CYC_W(CYC_W)) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .vld_i     (smp_vld),
            .below_i   (below[p]),
            .zx_i      (smp_zx[p]),
            .restart_i (cyc_restart),
            .cyc_i     (cyc),
            .evt_o     (evt_w[p])
        );
    end

    vsag_csr #(
        .NPH(NPH), .SW(SW), .CYC_W(CYC_W), .AW(AW), .DW(DW)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .evt_i     (evt_w),
        .thr_o     (thr),
        .cyc_o     (cyc),
        .restart_o (cyc_restart),
        .status_o  (status_w),
        .mask_o    (mask_w),
        .flags_o   (flags_w),
        .lvl_o     (lvl_w),
        .irq_n     (irq_n)
    );
endmodule

// File: rtl/vsag_monitor_chk.sv
module vsag_monitor_chk
    import vsag_pkg::*;
#(
    parameter int NPH = 3,
    parameter int SW  = 24,
    parameter int AW  = 3,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [DW-1:0]  wr_data,
    input logic [AW-1:0]  rd_addr,
    input logic [DW-1:0]  rd_data,
    input logic           irq_n,
    input logic           status,
    input logic           mask,
    input logic [NPH-1:0] flags,
    input logic [SW-1:0]  lvl,
    input logic [NPH-1:0] evt
);
    // R6
    flags_imply_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags) |-> status);

    // R7
    irq_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(status && mask));

    // R8
    ack_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADDR_STS) && wr_data[STAT_BIT] && evt == '0)
        |=> (!status && flags == '0 && irq_n));

    // R9
    low_level_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> ($past(lvl) > SW'(1)));

    // R5
    cyc_write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADDR_CYC)) |-> (evt == '0));

    // R10
    lvl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == AW'(ADDR_LVL)) |-> (rd_data[DW-1:SW] == '0 && rd_data[SW-1:0] == lvl));
endmodule

bind vsag_monitor vsag_monitor_chk #(
    .NPH(NPH), .SW(SW), .AW(AW), .DW(DW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq_n   (irq_n),
    .status  (status_w),
    .mask    (mask_w),
    .flags   (flags_w),
    .lvl     (lvl_w),
    .evt     (evt_w)
);

// File: tb/sim_vsag_monitor.sv
module sim_vsag_monitor;
    localparam logic [23:0] LVL    = 24'h100000;
    localparam logic [23:0] BIG    = 24'h200000;
    localparam logic [23:0] NEGBIG = 24'hD00000;  // -0x300000
    localparam logic [23:0] SMALL  = 24'h000064;
    localparam logic [23:0] NSMALL = 24'hFFFF9C;  // -100
    localparam logic [23:0] EQNEG  = 24'hF00000;  // magnitude equals LVL
    localparam logic [31:0] B16    = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [71:0] smp_data = '0;
    logic [2:0]  smp_zx = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_n;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] data;
        logic        irq;
        logic [7:0]  req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    vsag_monitor u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .smp_zx(smp_zx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    // monitor: pops expected items and compares settled outputs
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                rd_addr = it.addr;
                #1;
                nchk++;
                if (rd_data !== it.data || irq_n !== it.irq) begin
                    nerr++;
                    $display("FAIL R%0d addr %0d: actual data %h irq_n %b, expected data %h irq_n %b",
                             it.req, it.addr, rd_data, irq_n, it.data, it.irq);
                end
            end
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [31:0] d,
                             input logic irq, input logic [7:0] req);
        sb.push_back('{addr: a, data: d, irq: irq, req: req});
        wait (sb.size() == 0);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic smp(input logic [23:0] a, input logic [23:0] b,
                       input logic [23:0] c, input logic [2:0] zx);
        smp_vld = 1'b1; smp_data = {c, b, a}; smp_zx = zx;
        @(negedge clk);
        smp_vld = 1'b0; smp_zx = '0;
    endtask

    task automatic rearm();
        smp(BIG, BIG, NEGBIG, 3'b000);
    endtask

    task automatic ack();
        wr(3'd3, B16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        expect_rd(3'd0, 32'h0, 1'b1, 8'd11);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd11);
        expect_rd(3'd4, 32'h0, 1'b1, 8'd11);

        // R10 readback widths
        wr(3'd0, 32'hAB10_0000);
        expect_rd(3'd0, 32'h0010_0000, 1'b1, 8'd10);
        wr(3'd1, 32'd3);
        expect_rd(3'd1, 32'd3, 1'b1, 8'd10);
        wr(3'd2, B16);

        // R2 phase A qualifies on third strobe; strobe-less samples do not count
        smp(SMALL, BIG, NEGBIG, 3'b001);
        smp(SMALL, BIG, NEGBIG, 3'b000);
        smp(NSMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd2);
        smp(NSMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd3, B16, 1'b0, 8'd2);
        expect_rd(3'd4, 32'h1000, 1'b0, 8'd2);  // R1 negative magnitude below

        // R6 phase B replaces phase A flag
        smp(SMALL, SMALL, NEGBIG, 3'b010);
        smp(SMALL, SMALL, NEGBIG, 3'b010);
        smp(SMALL, SMALL, NEGBIG, 3'b010);
        expect_rd(3'd4, 32'h2000, 1'b0, 8'd6);
        expect_rd(3'd3, B16, 1'b0, 8'd6);

        // R8 bit16=0 no effect, then acknowledge
        wr(3'd3, 32'h0000_FFFF);
        expect_rd(3'd3, B16, 1'b0, 8'd8);
        ack();
        expect_rd(3'd3, 32'h0, 1'b1, 8'd8);
        expect_rd(3'd4, 32'h0, 1'b1, 8'd8);

        // R3 saturated phase does not re-fire; equal magnitude re-arms (R1)
        smp(SMALL, BIG, NEGBIG, 3'b001);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd3);
        smp(EQNEG, BIG, NEGBIG, 3'b000);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd1);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd4, 32'h1000, 1'b0, 8'd3);
        ack();

        // R4 level write keeps the count
        rearm();
        smp(SMALL, BIG, NEGBIG, 3'b001);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        wr(3'd0, 32'h0018_0000);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd4);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd4, 32'h1000, 1'b0, 8'd4);
        ack();
        wr(3'd0, {8'h0, LVL});

        // R5 cycle write restarts the count
        rearm();
        smp(SMALL, BIG, NEGBIG, 3'b001);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        wr(3'd1, 32'd3);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd5);
        smp(SMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd4, 32'h1000, 1'b0, 8'd5);
        ack();

        // R5 cycle count zero never raises
        wr(3'd1, 32'd0);
        rearm();
        for (int i = 0; i < 5; i++) smp(SMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd5);
        wr(3'd1, 32'd3);

        // R7 mask off then on
        wr(3'd2, 32'h0);
        rearm();
        for (int i = 0; i < 3; i++) smp(SMALL, BIG, NEGBIG, 3'b001);
        expect_rd(3'd3, B16, 1'b1, 8'd7);
        wr(3'd2, B16);
        expect_rd(3'd2, B16, 1'b0, 8'd7);
        ack();
        expect_rd(3'd3, 32'h0, 1'b1, 8'd7);

        // R9 level 1 and level 0
        wr(3'd0, 32'd1);
        expect_rd(3'd0, 32'd1, 1'b1, 8'd9);
        for (int i = 0; i < 5; i++) smp(24'h0, 24'h0, 24'h0, 3'b111);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd9);
        wr(3'd0, 32'd0);
        for (int i = 0; i < 5; i++) smp(24'h0, 24'h0, 24'h0, 3'b111);
        expect_rd(3'd3, 32'h0, 1'b1, 8'd9);

        // R6 simultaneous sags on all phases
        wr(3'd0, {8'h0, LVL});
        rearm();
        for (int i = 0; i < 3; i++) smp(SMALL, NSMALL, SMALL, 3'b111);
        expect_rd(3'd4, 32'h7000, 1'b0, 8'd6);
        ack();
        expect_rd(3'd4, 32'h0, 1'b1, 8'd8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
            $finish;
        end
    end
endmodule